// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block sits beside a DRAM access controller. It brings an asynchronous DRAM with an internal refresh row counter out of power-up and then keeps it refreshed. After reset it waits out a long power-up pause. It then asks the access controller for the bus and runs a burst of CAS-before-RAS refresh cycles. Once that burst is done, it raises `ready` and from then on owes one refresh per fixed interval.

The scheduler never drives the DRAM on its own authority. It raises `rf_req`, and only when the controller answers with `rf_gnt` does it start a cycle. It then raises `rf_drive` and produces the RAS, CAS and WE levels that the controller muxes onto the pins while the grant is held. In each cycle CAS falls first, WE stays high so the cycle is never read as a test-mode entry, and RAS follows after a set-up gap. The DRAM's own counter picks the row, so no address is produced.

Intervals that pass without a grant are counted in a small saturating backlog, and `backlog_over` reports when that backlog grows past a set limit. All timing values are parameters counted in clock cycles. The defaults assume an 8 ns clock: a 200 µs pause, eight initialization cycles, and a 1950-cycle interval, which keeps 1024 refreshes inside 16 ms. A low-power grade with its 128 ms window only needs a larger interval value.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low and right after it, `rf_req`, `ready`, `rf_drive` and `backlog_over` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: The first `rf_req` appears exactly PAUSE_CYC clock edges after reset is released, and none appears earlier.
- R3: Exactly INIT_CNT granted refresh cycles run before `ready` rises. `ready` rises on the edge that ends the last of them and stays high until reset.
- R4: Each granted cycle keeps `rf_drive` high for its whole length. It holds RAS and CAS high for RPC_CYC cycles, then CAS low with RAS high for CSR_CYC cycles, then both low for RASL_CYC cycles, then both high for RP_CYC cycles, after which `rf_drive` falls.
- R5: `we_n` is 1 in every cycle of every refresh sequence.
- R6: `rf_req` is 0 while `rf_drive` is 1. A grant that arrives while `rf_req` is 0 starts no cycle and changes no owed count.
- R7: Once `ready` is high, one refresh becomes owed every INTERVAL_CYC edges, the first INTERVAL_CYC edges after the edge that raised `ready`. `rf_req` is 1 whenever a refresh is owed and no sequence is running.
- R8: The owed count grows on each interval while no grant comes, saturates at OWED_MAX, and loses one for each granted sequence.
- R9: `backlog_over` is 1 exactly while the owed count is greater than OWED_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with the clock |
| rf_req | output | 1 | Refresh cycle wanted |
| rf_gnt | input | 1 | Controller hands the DRAM pins to the scheduler |
| ready | output | 1 | Initialization done, normal accesses allowed |
| rf_drive | output | 1 | Pin levels below are valid and must be muxed onto the DRAM |
| ras_n | output | 1 | Row strobe level |
| cas_n | output | 1 | Column strobe level |
| we_n | output | 1 | Write enable level |
| backlog_over | output | 1 | Owed refreshes exceed OWED_LIMIT |

## Verification
The bench builds the block with a 50-cycle pause, a 40-cycle interval, sequence phases of 1, 2, 4 and 3 cycles, OWED_MAX of 3 and OWED_LIMIT of 2. These short values put the full initialization burst, several intervals and a saturated backlog within a few hundred cycles. The backlog limit can then be crossed and the saturation seen by counting how many back-to-back sequences drain it. The interval is four times the sequence length, so a drained backlog finishes well before the next interval ends.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_CAS,
    SQ_RAS,
    SQ_RCV
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dref_period.sv
module dref_period #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == PW'(PERIOD - 1));

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int OWED_MAX   = 7,
  parameter int OWED_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pending,
  output logic over
);
  localparam int OW = $clog2(OWED_MAX + 1);

  logic [OW-1:0] owed_q, owed_d;
  logic          over_q;

  always_comb begin
    owed_d = owed_q;
    if (tick && !take && (owed_q != OW'(OWED_MAX))) owed_d = owed_q + OW'(1);
    else if (take && !tick)                         owed_d = owed_q - OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      over_q <= 1'b0;
    end else begin
      owed_q <= owed_d;
      over_q <= (owed_d > OW'(OWED_LIMIT));
    end
  end

  assign pending = (owed_q != '0);
  assign over    = over_q;

  a_r9_flag_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over) |-> $past(tick));

  a_r8_take_needs_owed: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);

endmodule

// File: rtl/dref_cbr_seq.sv
module dref_cbr_seq
  import dref_pkg::*;
#(
  parameter int RPC_CYC  = 1,
  parameter int CSR_CYC  = 2,
  parameter int RASL_CYC = 8,
  parameter int RP_CYC   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int LMAX = max_of4(RPC_CYC, CSR_CYC, RASL_CYC, RP_CYC);
  localparam int CW   = (LMAX > 1) ? $clog2(LMAX) : 1;

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, ras_q, cas_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start) begin
        st_d  = SQ_PRE;
        cnt_d = CW'(RPC_CYC - 1);
      end
      SQ_PRE: if (last) begin
        st_d  = SQ_CAS;
        cnt_d = CW'(CSR_CYC - 1);
      end else cnt_d = cnt_q - CW'(1);
      SQ_CAS: if (last) begin
        st_d  = SQ_RAS;
        cnt_d = CW'(RASL_CYC - 1);
      end else cnt_d = cnt_q - CW'(1);
      SQ_RAS: if (last) begin
        st_d  = SQ_RCV;
        cnt_d = CW'(RP_CYC - 1);
      end else cnt_d = cnt_q - CW'(1);
      SQ_RCV: if (last) begin
        st_d = SQ_IDLE;
        done = 1'b1;
      end else cnt_d = cnt_q - CW'(1);
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      busy_q <= (st_d != SQ_IDLE);
      ras_q  <= (st_d != SQ_RAS);
      cas_q  <= !((st_d == SQ_CAS) || (st_d == SQ_RAS));
    end
  end

  assign busy  = busy_q;
  assign ras_n = ras_q;
  assign cas_n = cas_q;

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  a_r4_cas_falls_with_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  a_r4_strobes_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));

  a_r4_strobes_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> busy);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INIT_CNT     = 8,
  parameter int INTERVAL_CYC = 1950,
  parameter int RPC_CYC      = 1,
  parameter int CSR_CYC      = 2,
  parameter int RASL_CYC     = 8,
  parameter int RP_CYC       = 5,
  parameter int OWED_MAX     = 7,
  parameter int OWED_LIMIT   = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic rf_req,
  input  logic rf_gnt,
  output logic ready,
  output logic rf_drive,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic backlog_over
);
  localparam int IW = $clog2(INIT_CNT + 1);

  phase_e        ph_q, ph_d;
  logic [IW-1:0] init_q, init_d;
  logic          pause_tick, run_tick;
  logic          owed, busy, seq_done, start;

  dref_period #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(ph_q == PH_PAUSE), .tick(pause_tick));

  dref_period #(.PERIOD(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(ph_q == PH_RUN), .tick(run_tick));

  dref_backlog #(.OWED_MAX(OWED_MAX), .OWED_LIMIT(OWED_LIMIT)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(run_tick),
    .take(start && (ph_q == PH_RUN)), .pending(owed), .over(backlog_over));

  dref_cbr_seq #(.RPC_CYC(RPC_CYC), .CSR_CYC(CSR_CYC),
                 .RASL_CYC(RASL_CYC), .RP_CYC(RP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(seq_done), .ras_n(ras_n), .cas_n(cas_n));

  assign rf_req = !busy && (((ph_q == PH_INIT) && (init_q != '0)) ||
                            ((ph_q == PH_RUN) && owed));
  assign start  = rf_req && rf_gnt;

  always_comb begin
    ph_d   = ph_q;
    init_d = init_q;
    unique case (ph_q)
      PH_PAUSE: if (pause_tick) ph_d = PH_INIT;
      PH_INIT: begin
        if (start) init_d = init_q - IW'(1);
        if (seq_done && (init_q == '0)) ph_d = PH_RUN;
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_PAUSE;
      init_q <= IW'(INIT_CNT);
    end else begin
      ph_q   <= ph_d;
      init_q <= init_d;
    end
  end

  assign ready    = (ph_q == PH_RUN);
  assign rf_drive = busy;
  assign we_n     = 1'b1;

  a_r3_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r3_ready_after_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(seq_done));

  a_r6_stray_grant_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_gnt && !rf_req && !rf_drive) |=> !rf_drive);

  a_r6_drive_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_drive) |-> $past(rf_req && rf_gnt));

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int PAUSE = 50;
  localparam int INIT  = 8;
  localparam int IVL   = 40;
  localparam int RPC   = 1;
  localparam int CSR   = 2;
  localparam int RASL  = 4;
  localparam int RP    = 3;
  localparam int OMAX  = 3;
  localparam int OLIM  = 2;

  logic clk, rst_n, rf_req, rf_gnt, ready, rf_drive, ras_n, cas_n, we_n, backlog_over;
  int   cyc, total, bad, t0, tr;
  bit   finished;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .INTERVAL_CYC(IVL),
    .RPC_CYC(RPC), .CSR_CYC(CSR), .RASL_CYC(RASL), .RP_CYC(RP),
    .OWED_MAX(OMAX), .OWED_LIMIT(OLIM)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .rf_req(rf_req), .rf_gnt(rf_gnt),
    .ready(ready), .rf_drive(rf_drive), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .backlog_over(backlog_over));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic at(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic run_seq(output int npre, output int ncs, output int nrl, output int npost,
                         output int bwe, output int breq, output int bord);
    int ph;
    int guard;
    ph = 0; npre = 0; ncs = 0; nrl = 0; npost = 0; bwe = 0; breq = 0; bord = 0; guard = 0;
    rf_gnt = 1'b1;
    @(negedge clk);
    while (rf_drive && guard < 100) begin
      guard++;
      if (!we_n) bwe++;
      if (rf_req) breq++;
      if (ras_n && cas_n) begin
        if (ph == 0) npre++;
        else begin ph = 3; npost++; end
      end else if (ras_n && !cas_n) begin
        if (ph > 1) bord++;
        ph = 1; ncs++;
      end else if (!ras_n && !cas_n) begin
        if (ph == 0 || ph == 3) bord++;
        ph = 2; nrl++;
      end else bord++;
      @(negedge clk);
    end
    rf_gnt = 1'b0;
  endtask

  task automatic check_seq(input string tag);
    int a, b, c, d, e, f, g;
    run_seq(a, b, c, d, e, f, g);
    chk(a == RPC,  "R4", {tag, " precharge cycles"}, a, RPC);
    chk(b == CSR,  "R4", {tag, " CAS-only cycles"}, b, CSR);
    chk(c == RASL, "R4", {tag, " RAS low cycles"}, c, RASL);
    chk(d == RP,   "R4", {tag, " recovery cycles"}, d, RP);
    chk(g == 0,    "R4", {tag, " strobe order errors"}, g, 0);
    chk(e == 0,    "R5", {tag, " WE low cycles"}, e, 0);
    chk(f == 0,    "R6", {tag, " request while driving"}, f, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rf_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rf_req && !ready && !rf_drive && !backlog_over, "R1", "outputs low in reset",
        {rf_req, ready, rf_drive, backlog_over}, 0);
    chk(ras_n && cas_n && we_n, "R1", "strobes high in reset", {ras_n, cas_n, we_n}, 7);
    rst_n = 1'b1;
    t0 = cyc;
    @(negedge clk);
    chk(!rf_req && !ready && !rf_drive && ras_n && cas_n, "R1", "state after release",
        {rf_req, ready, rf_drive, ras_n, cas_n}, 3);
  endtask

  task automatic t_pause;
    at(t0 + 10);
    rf_gnt = 1'b1;
    @(negedge clk);
    rf_gnt = 1'b0;
    chk(!rf_drive, "R6", "grant during pause ignored", rf_drive, 0);
    at(t0 + PAUSE - 1);
    chk(!rf_req, "R2", "no request before pause ends", rf_req, 0);
    at(t0 + PAUSE);
    chk(rf_req, "R2", "request when pause ends", rf_req, 1);
  endtask

  task automatic t_init;
    for (int k = 0; k < INIT; k++) begin
      chk(rf_req, "R3", "init request present", rf_req, 1);
      chk(!ready, "R3", "not ready during init", ready, 0);
      check_seq("init");
    end
    chk(ready, "R3", "ready after init burst", ready, 1);
    tr = cyc;
  endtask

  task automatic t_interval;
    at(tr + 5);
    rf_gnt = 1'b1;
    @(negedge clk);
    rf_gnt = 1'b0;
    chk(!rf_drive, "R6", "grant with no request ignored", rf_drive, 0);
    at(tr + IVL - 1);
    chk(!rf_req, "R7", "no request before first interval", rf_req, 0);
    chk(!rf_drive, "R6", "stray grant left nothing owed", rf_drive, 0);
    at(tr + IVL);
    chk(rf_req, "R7", "request at first interval", rf_req, 1);
    check_seq("run");
    chk(!rf_req, "R8", "owed cleared by one sequence", rf_req, 0);
    chk(ready, "R3", "ready stays high", ready, 1);
  endtask

  task automatic t_backlog;
    int n;
    at(tr + 2 * IVL);
    chk(rf_req, "R7", "request at second interval", rf_req, 1);
    at(tr + 4 * IVL - 1);
    chk(!backlog_over, "R9", "flag low at owed==limit", backlog_over, 0);
    at(tr + 4 * IVL);
    chk(backlog_over, "R9", "flag high above limit", backlog_over, 1);
    at(tr + 5 * IVL + 1);
    chk(backlog_over, "R9", "flag held while saturated", backlog_over, 1);
    n = 0;
    while (rf_req && n < 10) begin
      check_seq("drain");
      n++;
      if (n == 1) chk(!backlog_over, "R9", "flag clears after one retire", backlog_over, 0);
    end
    chk(n == OMAX, "R8", "saturated backlog drain count", n, OMAX);
    chk(!rf_req, "R8", "no request after drain", rf_req, 0);
    at(tr + 6 * IVL);
    chk(rf_req, "R7", "interval continues after drain", rf_req, 1);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    t_reset;
    t_pause;
    t_init;
    t_interval;
    t_backlog;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule